// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This unit produces the 13-bit instruction address for a processor that has 14-bit instruction words and an 8192-word program space. On every instruction cycle it applies one flow action. The address can step to the next word. It can load an 11-bit target from a jump or call. It can take a computed jump when software writes the low address byte. It can pop a return address from an internal stack. It can also vector to the interrupt entry. A 5-bit upper-address latch lives at file address 0x0A and supplies the address bits that an instruction cannot carry.

The return stack has eight entries of 13 bits. Software cannot read it, and it has no overflow or underflow reporting. It works as a ring, so a ninth push replaces the oldest entry. The fetch pipeline consumes a one-cycle `flush` pulse after every non-sequential load. That pulse lets it discard the word it prefetched, which gives branching instructions their second cycle.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `pc` is 0x000 and `flush` is 0. The latch, the stack pointer and all stack entries are cleared.
- R2: In a cycle with no interrupt, `opKind` = 0 (none) and no write to file address 0x02, `pc` becomes `pc`+1 at the next edge. It wraps from 0x1FFF to 0x000.
- R3: When `opKind` = 1 (jump), `pc` becomes {latch[4:3], `target[10:0]`}.
- R4: When `opKind` = 2 (call), the unit pushes `pc`+1 and loads `pc` as a jump does. When `opKind` = 3 (return), `pc` is loaded from the top stack entry and that entry is popped.
- R5: With `opKind` = 0 and no interrupt, a write (`regWrEn`=1) to file address 0x02 loads `pc` with {latch[4:0], `regWrData`}. A flow operation in the same cycle takes precedence over this write.
- R6: A write to file address 0x0A stores `regWrData[4:0]` in the latch, even during an interrupt. A jump, call or computed jump in the same cycle still uses the previous latch value.
- R7: `irqTake` overrides every flow operation and any computed jump in that cycle. It pushes the current `pc` and loads 0x004.
- R8: The stack holds 8 entries. A ninth push overwrites the oldest entry with no indication. Pops wrap around the ring, so after nine pushes the ninth pop returns the ninth pushed value again.
- R9: `flush` is 1 for exactly the cycle that follows any `pc` load other than a sequential increment, and 0 otherwise.
- R10: A write to any file address other than 0x02 or 0x0A leaves `pc` stepping sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| opKind | input | 2 | Flow action: 0 none, 1 jump, 2 call, 3 return |
| target | input | 11 | Jump/call target field of the instruction |
| irqTake | input | 1 | Interrupt accepted this cycle |
| regWrEn | input | 1 | File register write strobe |
| regAddr | input | 7 | File register address of the write |
| regWrData | input | 8 | File register write data |
| pc | output | 13 | Current program counter |
| flush | output | 1 | Discard prefetched word this cycle |

## Verification
A corrupted stack pointer or stack entry stays hidden until a return executes. It then appears at the ports as a wrong `pc` on the cycle after that return, so the bench checks call and return sequences that reach past eight levels. A stale or wrongly sized latch appears only on the next jump or computed jump, in the top `pc` bits. A wrong flush register shows up one cycle after every load. The reference model is compared on every clock, so each of these faults is caught within one cycle of the first instruction that exposes it.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_JUMP = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } flowOp_e;

  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_JUMP = 3'd1,
    SEL_PCL  = 3'd2,
    SEL_POP  = 3'd3,
    SEL_VEC  = 3'd4
  } pcSel_e;

  typedef struct packed {
    pcSel_e sel;       // source of the next pc
    logic   push;      // write a return address
    logic   pushNext;  // push pc+1 instead of pc
    logic   latchWr;   // update upper-address latch
  } pcStrobe_t;

endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int LATCH_ADDR = 7'h0A,
  parameter int PCL_ADDR   = 7'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  flowOp_e           opKind,
  input  logic              irqTake,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output pcStrobe_t         strb,
  output logic              flush
);

  localparam logic [ADDR_W-1:0] LatchSel = ADDR_W'(LATCH_ADDR);
  localparam logic [ADDR_W-1:0] PclSel   = ADDR_W'(PCL_ADDR);

  logic pclHit;
  logic flushQ;

  assign pclHit = regWrEn && (regAddr == PclSel);

  always_comb begin
    strb          = '0;
    strb.sel      = SEL_INC;
    strb.latchWr  = regWrEn && (regAddr == LatchSel);
    if (irqTake) begin
      strb.sel  = SEL_VEC;
      strb.push = 1'b1;
    end else begin
      unique case (opKind)
        OP_JUMP: strb.sel = SEL_JUMP;
        OP_CALL: begin
          strb.sel      = SEL_JUMP;
          strb.push     = 1'b1;
          strb.pushNext = 1'b1;
        end
        OP_RET:  strb.sel = SEL_POP;
        default: if (pclHit) strb.sel = SEL_PCL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flushQ <= 1'b0;
    else       flushQ <= (strb.sel != SEL_INC);
  end

  assign flush = flushQ;

  // R9: an accepted interrupt must be followed by a flush cycle
  p_irq_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |=> flush);

  // R10: a write elsewhere with no flow op gives no flush
  p_other_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && opKind == OP_NONE && regWrEn && regAddr != PclSel) |=> !flush);

endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int JMP_W  = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int IRQ_VEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strb,
  input  logic [JMP_W-1:0]  target,
  input  logic [DATA_W-1:0] wrData,
  output logic [PC_W-1:0]   pc
);

  localparam int SP_W    = $clog2(DEPTH);
  localparam int LATCH_W = PC_W - DATA_W;
  localparam int HI_W    = PC_W - JMP_W;

  logic [PC_W-1:0]    pcQ;
  logic [PC_W-1:0]    pcInc;
  logic [PC_W-1:0]    pcNext;
  logic [PC_W-1:0]    pushVal;
  logic [LATCH_W-1:0] latchQ;
  logic [SP_W-1:0]    spQ;
  logic [SP_W-1:0]    spTop;
  logic [PC_W-1:0]    stackMem [DEPTH];

  assign pcInc   = pcQ + 1'b1;
  assign pushVal = strb.pushNext ? pcInc : pcQ;
  assign spTop   = spQ - 1'b1;

  always_comb begin
    unique case (strb.sel)
      SEL_JUMP: pcNext = {latchQ[LATCH_W-1 -: HI_W], target};
      SEL_PCL:  pcNext = {latchQ, wrData};
      SEL_POP:  pcNext = stackMem[spTop];
      SEL_VEC:  pcNext = PC_W'(IRQ_VEC);
      default:  pcNext = pcInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ    <= '0;
      latchQ <= '0;
      spQ    <= '0;
    end else begin
      pcQ <= pcNext;
      if (strb.latchWr) latchQ <= wrData[LATCH_W-1:0];
      if (strb.push)             spQ <= spQ + 1'b1;
      else if (strb.sel == SEL_POP) spQ <= spTop;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                                stackMem[i] <= '0;
      else if (strb.push && spQ == SP_W'(i))    stackMem[i] <= pushVal;
    end
  end

  assign pc = pcQ;

  // R2: a sequential cycle advances by exactly one
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_INC) |=> pc == PC_W'($past(pc) + 1'b1));

  // R7: vectoring lands on the interrupt entry
  p_vector_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_VEC) |=> pc == PC_W'(IRQ_VEC));

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pc_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int JMP_W   = 11,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int DEPTH   = 8,
  parameter int IRQ_VEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opKind,
  input  logic [JMP_W-1:0]  target,
  input  logic              irqTake,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [PC_W-1:0]   pc,
  output logic              flush
);

  flowOp_e   opE;
  pcStrobe_t strb;

  assign opE = flowOp_e'(opKind);

  pc_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opKind  (opE),
    .irqTake (irqTake),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .flush   (flush)
  );

  pc_datapath #(
    .PC_W   (PC_W),
    .JMP_W  (JMP_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IRQ_VEC(IRQ_VEC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .target (target),
    .wrData (regWrData),
    .pc     (pc)
  );

  // R3: the low bits after a jump are the target field
  p_jump_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && opKind == 2'd1) |=> pc[JMP_W-1:0] == $past(target));

  // R4: a call immediately returned resumes after the call
  p_call_ret_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && opKind == 2'd2) ##1 (!irqTake && opKind == 2'd3)
      |=> pc == PC_W'($past(pc, 2) + 1'b1));

  // R5: computed jump takes the written byte as low bits
  p_pcl_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqTake && opKind == 2'd0 && regWrEn && regAddr == ADDR_W'(2))
      |=> pc[DATA_W-1:0] == $past(regWrData));

  // R9: flush never lasts two cycles without a fresh load
  p_flush_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !irqTake && opKind == 2'd0 && !(regWrEn && regAddr == ADDR_W'(2)))
      |=> !flush);

endmodule

// File: tb/pc_stack_unit_tb.sv
module pc_stack_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opKind = 2'd0;
  logic [10:0] target = '0;
  logic        irqTake = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [12:0] pc;
  logic        flush;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mPc = 0;
  int mLatch = 0;
  int mFlush = 0;
  int ring[$];

  always #5 clk = ~clk;

  pc_stack_unit u_dut (
    .clk(clk), .rstN(rstN), .opKind(opKind), .target(target),
    .irqTake(irqTake), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pc(pc), .flush(flush)
  );

  task automatic check(string tag);
    total++;
    if (int'(pc) != mPc) begin
      bad++;
      $display("FAIL %s pc actual=%h expected=%h", tag, pc, mPc);
    end
    total++;
    if (int'(flush) != mFlush) begin
      bad++;
      $display("FAIL %s flush actual=%0d expected=%0d", tag, flush, mFlush);
    end
  endtask

  task automatic pushRing(int v);
    ring.push_front(v);
    if (ring.size() > 8) void'(ring.pop_back());
  endtask

  task automatic step(int op, int tgt, bit wr, int addr, int data, bit irq, string tag);
    int v;
    opKind = 2'(op); target = 11'(tgt); regWrEn = wr;
    regAddr = 7'(addr); regWrData = 8'(data); irqTake = irq;
    @(posedge clk);
    mFlush = 1;
    if (irq) begin
      pushRing(mPc); mPc = 4;
    end else if (op == 1) begin
      mPc = ((mLatch >> 3) << 11) | tgt;
    end else if (op == 2) begin
      pushRing((mPc + 1) % 8192);
      mPc = ((mLatch >> 3) << 11) | tgt;
    end else if (op == 3) begin
      v = ring.pop_front(); ring.push_back(v); mPc = v;
    end else if (wr && addr == 2) begin
      mPc = (mLatch << 8) | data;
    end else begin
      mPc = (mPc + 1) % 8192; mFlush = 0;
    end
    if (wr && addr == 10) mLatch = data & 31;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ring.push_back(0);
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1 first cycle");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R2 increment");
    step(0, 0, 1, 7'h15, 8'h99, 0, "R10 other address");
    step(0, 0, 1, 7'h0A, 8'hF8, 0, "R6 latch write");
    step(1, 11'h123, 0, 0, 0, 0, "R3 jump with latch");
    step(0, 0, 0, 0, 0, 0, "R9 flush drops");
    step(1, 11'h7FF, 1, 7'h0A, 8'h00, 0, "R6 same-cycle latch old value");
    step(0, 0, 0, 0, 0, 0, "R2 wrap to zero");
    step(1, 11'h0A0, 0, 0, 0, 0, "R3 jump latch cleared");
    step(2, 11'h200, 0, 0, 0, 0, "R4 call");
    step(2, 11'h300, 0, 0, 0, 0, "R4 nested call");
    step(0, 0, 0, 0, 0, 0, "R2 in subroutine");
    step(3, 0, 0, 0, 0, 0, "R4 return inner");
    step(3, 0, 0, 0, 0, 0, "R4 return outer");
    step(0, 0, 1, 7'h0A, 8'h13, 0, "R6 latch write");
    step(0, 0, 1, 7'h02, 8'h5C, 0, "R5 computed jump");
    step(1, 11'h011, 1, 7'h02, 8'hEE, 0, "R5 flow op wins");
    step(0, 0, 1, 7'h02, 8'h40, 1, "R7 irq beats computed jump");
    step(0, 0, 0, 0, 0, 0, "R7 vector then step");
    step(3, 0, 0, 0, 0, 0, "R7 return from interrupt");
    step(1, 11'h055, 1, 7'h0A, 8'h08, 1, "R7 irq beats jump, latch still written");
    step(3, 0, 0, 0, 0, 0, "R7 return after irq");
    step(1, 11'h100, 0, 0, 0, 0, "R3 jump uses latch from irq cycle");
    for (int i = 0; i < 9; i++) step(2, 11'h010 + 11'(i * 16), 0, 0, 0, 0, "R8 deep call");
    for (int i = 0; i < 10; i++) step(3, 0, 0, 0, 0, 0, "R8 circular pop");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R9 no flush when sequential");
    rstN = 1'b0;
    @(negedge clk);
    mPc = 0; mFlush = 0; mLatch = 0;
    ring.delete();
    for (int i = 0; i < 8; i++) ring.push_back(0);
    check("R1 re-reset");
    rstN = 1'b1;
    step(3, 0, 0, 0, 0, 0, "R1 cleared stack pops zero");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule